// File: doc/BRIEF.md
# Backplane Burst Write Master

This block is the transaction master for a backplane whose address and data share one 32-bit active-low wire set. It only writes. The block assumes that bus ownership has already been granted. A local requester hands it an address, four data words and a flag. The flag selects either a four-word burst or a single-word write. When the slave's acknowledge comes back, the block returns a one-clock completion pulse with a two-bit status.

A burst has a fixed sequence of phases: a start cycle, two data cycles, a cycle in which the master releases the lines, and an acknowledge cycle. Each data cycle carries two words. They are presented as a 64-bit pair on `ad_n`, with one strobe bit per word, so that a double-rate pad cell can put the pair onto the 32 physical wires. Two throttles can stretch either data cycle: the local side raises `lhold`, which the block echoes on `drq_n`, or the slave pulls `tm_in_n[0]` low. A single-word write holds its word on the lines until the slave acknowledges. The block ends the transaction with a timeout status if no acknowledge arrives within a programmable number of clocks.

Top module: `bpl_burst_master`

## Requirements
- R1: While reset is asserted and afterwards in idle, the block drives these values: `ad_oe`=0, `ad_n` all ones, `dstb_n`=11, `start_n`=1, `burst_n`=1, `drq_n`=1, `done`=0, `busy`=0.
- R2: The cycle after a request is accepted is the start cycle, and it lasts one clock. In it, `start_n`=0, `ad_n[31:0]` = ~address, `ad_n[63:32]` = all ones, `ad_oe`=1, and `burst_n`=0 exactly when a burst was requested.
- R3: The burst data cycles work as follows. In the first, `ad_n` = ~{word1,word0} with `dstb_n`=00. In the second, `ad_n` = ~{word3,word2} with `dstb_n`=00. The lower half always carries the earlier word.
- R4: A burst data cycle in which `lhold`=1 or `tm_in_n[0]`=0 does not strobe (`dstb_n`=11). It keeps the same data and is repeated on the next clock. `drq_n`=0 exactly when `lhold`=1 during a burst data cycle.
- R5: After the second data cycle the block spends one cycle with `ad_oe`=0 and `dstb_n`=11, and then waits for `ack_n`=0. With no throttling and an immediate acknowledge, a burst takes five clocks from the start cycle to the acknowledge cycle.
- R6: A single-word write has a start cycle followed by data cycles. In each data cycle `ad_n` = {all ones, ~word0} and `dstb_n`=10, held unchanged until the acknowledge is sampled. An acknowledge in the first data cycle is ignored, so the minimum is three clocks.
- R7: `done` rises one clock after the acknowledge cycle. `done_status` then equals ~`tm_in_n` as sampled in that cycle. The encoding is 00 success, 01 retry, 10 bus error, 11 timeout.
- R8: The wait is limited to max(`tmo_lim`,1) cycles. If `ack_n` stays high for that many waiting cycles, `done` rises on the next clock with `done_status`=11.
- R9: `done` lasts exactly one clock. A request is accepted only in idle, and requests raised while busy are dropped.
- R10: `busy` is high from the start cycle through the acknowledge (or timeout) cycle, and low while `done` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Request strobe, taken only in idle |
| req_burst | input | 1 | 1 = four-word burst, 0 = single word |
| req_addr | input | 32 | Target address |
| req_data | input | 128 | Four words, word0 in the low bits |
| tmo_lim | input | 8 | Acknowledge wait limit in clocks (0 acts as 1) |
| lhold | input | 1 | Local throttle for burst data cycles |
| done | output | 1 | One-clock completion pulse |
| done_status | output | 2 | Completion status |
| busy | output | 1 | Transaction in progress |
| ad_n | output | 64 | Active-low word pair for the shared lines |
| ad_oe | output | 1 | Drive enable for `ad_n` |
| dstb_n | output | 2 | Active-low data strobe, one bit per word |
| start_n | output | 1 | Active-low start cycle marker |
| burst_n | output | 1 | Active-low burst mode, valid in the start cycle |
| drq_n | output | 1 | Active-low master throttle echo |
| tm_in_n | input | 2 | Slave lines: bit 0 is the throttle during data cycles; both bits carry the status in the acknowledge cycle |
| ack_n | input | 1 | Active-low slave acknowledge |

## Verification
The phase outputs decode directly from the state register, so each phase becomes visible in the clock after the edge that enters it. The start cycle follows the accepting edge by one clock, and `done` follows the acknowledge edge by one clock. The bench drives each cycle's inputs just after a falling edge and reads the outputs a moment later. It therefore walks a burst one clock at a time and checks the cycle it has just arranged. Throttle counts, acknowledge delays, status codes and timeout limits are swept, so every stretched position is checked on the cycle it is due.

// File: rtl/bpl_burst_master.sv
module bpl_burst_master #(
  parameter int W  = 32,
  parameter int TW = 8
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           req_valid,
  input  logic           req_burst,
  input  logic [W-1:0]   req_addr,
  input  logic [4*W-1:0] req_data,
  input  logic [TW-1:0]  tmo_lim,
  input  logic           lhold,
  output logic           done,
  output logic [1:0]     done_status,
  output logic           busy,
  output logic [2*W-1:0] ad_n,
  output logic           ad_oe,
  output logic [1:0]     dstb_n,
  output logic           start_n,
  output logic           burst_n,
  output logic           drq_n,
  input  logic [1:0]     tm_in_n,
  input  logic           ack_n
);

  typedef enum logic [2:0] {
    S_IDLE, S_START, S_D0, S_D1, S_REL, S_WAIT, S_SD1, S_SD2
  } state_t;

  state_t          st;
  logic            burst_q;
  logic [W-1:0]    addr_q;
  logic [4*W-1:0]  data_q;
  logic [TW-1:0]   cnt;

  logic hold, in_bdata, in_sdata, waiting, expired;

  assign hold     = lhold | ~tm_in_n[0];
  assign in_bdata = (st == S_D0) || (st == S_D1);
  assign in_sdata = (st == S_SD1) || (st == S_SD2);
  assign waiting  = (st == S_WAIT) || (st == S_SD2);
  assign expired  = ({1'b0, cnt} + 1'b1) >= {1'b0, tmo_lim};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st          <= S_IDLE;
      burst_q     <= 1'b0;
      addr_q      <= '0;
      data_q      <= '0;
      cnt         <= '0;
      done        <= 1'b0;
      done_status <= 2'b00;
    end else begin
      done <= 1'b0;
      case (st)
        S_IDLE:
          if (req_valid) begin
            burst_q <= req_burst;
            addr_q  <= req_addr;
            data_q  <= req_data;
            st      <= S_START;
          end
        S_START: begin
          cnt <= '0;
          st  <= burst_q ? S_D0 : S_SD1;
        end
        S_D0:  if (!hold) st <= S_D1;
        S_D1:  if (!hold) st <= S_REL;
        S_REL: st <= S_WAIT;
        S_SD1: st <= S_SD2;
        S_WAIT, S_SD2:
          if (!ack_n) begin
            done        <= 1'b1;
            done_status <= ~tm_in_n;
            st          <= S_IDLE;
          end else if (expired) begin
            done        <= 1'b1;
            done_status <= 2'b11;
            st          <= S_IDLE;
          end else begin
            cnt <= cnt + 1'b1;
          end
        default: st <= S_IDLE;
      endcase
    end
  end

  assign busy    = (st != S_IDLE);
  assign start_n = (st != S_START);
  assign burst_n = !((st == S_START) && burst_q);
  assign drq_n   = !(lhold && in_bdata);
  assign ad_oe   = (st == S_START) || in_bdata || in_sdata;

  assign ad_n = (st == S_START) ? {{W{1'b1}}, ~addr_q} :
                (st == S_D0)    ? ~data_q[2*W-1:0] :
                (st == S_D1)    ? ~data_q[4*W-1:2*W] :
                in_sdata        ? {{W{1'b1}}, ~data_q[W-1:0]} :
                                  {2*W{1'b1}};

  assign dstb_n = in_bdata ? (hold ? 2'b11 : 2'b00) :
                  in_sdata ? 2'b10 : 2'b11;

endmodule

// File: rtl/bpl_burst_master_chk.sv
module bpl_burst_master_chk #(
  parameter int W = 32
) (
  input logic           clk,
  input logic           rst_n,
  input logic           lhold,
  input logic [1:0]     tm_in_n,
  input logic [2*W-1:0] ad_n,
  input logic           ad_oe,
  input logic [1:0]     dstb_n,
  input logic           start_n,
  input logic           done,
  input logic           busy
);

  assert_done_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  assert_done_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);

  assert_start_single_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !start_n |=> start_n);

  assert_start_busy_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !start_n |-> busy);

  assert_strobe_driven_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (dstb_n != 2'b11) |-> ad_oe);

  assert_hold_blocks_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (dstb_n == 2'b00) |-> (!lhold && tm_in_n[0]));

  assert_single_stable_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (dstb_n == 2'b10) |=> (dstb_n != 2'b10) || $stable(ad_n));

endmodule

bind bpl_burst_master bpl_burst_master_chk #(.W(W)) u_chk (
  .clk(clk), .rst_n(rst_n), .lhold(lhold), .tm_in_n(tm_in_n), .ad_n(ad_n),
  .ad_oe(ad_oe), .dstb_n(dstb_n), .start_n(start_n), .done(done), .busy(busy)
);

// File: tb/sim_bpl_burst_master.sv
`timescale 1ns/1ps
module sim_bpl_burst_master;
  logic         clk = 1'b0;
  logic         rst_n;
  logic         req_valid, req_burst, lhold, ack_n;
  logic [31:0]  req_addr;
  logic [127:0] req_data;
  logic [7:0]   tmo_lim;
  logic [1:0]   tm_in_n;
  logic         done, busy, ad_oe, start_n, burst_n, drq_n;
  logic [1:0]   done_status, dstb_n;
  logic [63:0]  ad_n;

  int nchk = 0;
  int nfail = 0;
  int cyc = 0;

  always #5 clk = ~clk;

  bpl_burst_master u0 (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_burst(req_burst),
    .req_addr(req_addr), .req_data(req_data), .tmo_lim(tmo_lim), .lhold(lhold),
    .done(done), .done_status(done_status), .busy(busy), .ad_n(ad_n),
    .ad_oe(ad_oe), .dstb_n(dstb_n), .start_n(start_n), .burst_n(burst_n),
    .drq_n(drq_n), .tm_in_n(tm_in_n), .ack_n(ack_n)
  );

  task automatic chk(input bit ok, input string tag, input logic [127:0] act,
                     input logic [127:0] exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic int eff_lim();
    return (tmo_lim == 0) ? 1 : int'(tmo_lim);
  endfunction

  task automatic finish_txn(input logic [1:0] exp_st);
    @(negedge clk); ack_n = 1'b1; tm_in_n = 2'b11; #1;
    chk(done == 1'b1, "R7 done", done, 1);
    chk(done_status == exp_st, "R7/R8 status", done_status, exp_st);
    chk(!busy && start_n, "R9 dropped request", {busy, start_n}, 2'b01);
    @(negedge clk); #1;
    chk(done == 1'b0, "R9 one clock", done, 0);
  endtask

  task automatic wait_ack(input int d, input logic [1:0] s, input bit noack,
                          input logic [63:0] held);
    int n;
    n = noack ? eff_lim() : d;
    for (int j = 0; j < n; j++) begin
      @(negedge clk); ack_n = 1'b1; tm_in_n = 2'b11; #1;
      chk(busy && !done, "R8 waiting", {busy, done}, 2'b10);
      chk(ad_n == held, "R6 held", ad_n, held);
    end
    if (!noack) begin
      @(negedge clk); ack_n = 1'b0; tm_in_n = ~s; #1;
      chk(busy, "R10 busy ack", busy, 1);
    end
  endtask

  task automatic do_burst(input int h0, input int h1, input bit src, input int d,
                          input logic [1:0] s, input bit noack,
                          input logic [31:0] a, input logic [127:0] dat);
    @(negedge clk);
    req_valid = 1'b1; req_burst = 1'b1; req_addr = a; req_data = dat; #1;
    chk(!busy, "R9 idle accept", busy, 0);
    @(negedge clk); req_valid = 1'b0; #1;
    chk(!start_n && !burst_n && ad_oe, "R2 start", {start_n, burst_n, ad_oe}, 3'b001);
    chk(ad_n == {32'hFFFF_FFFF, ~a}, "R2 addr", ad_n, {32'hFFFF_FFFF, ~a});
    chk(busy, "R10 busy start", busy, 1);
    for (int ph = 0; ph < 2; ph++) begin
      logic [63:0] e;
      int h;
      e = (ph == 0) ? ~dat[63:0] : ~dat[127:64];
      h = (ph == 0) ? h0 : h1;
      for (int i = 0; i < h; i++) begin
        @(negedge clk);
        if (src) tm_in_n = 2'b10; else lhold = 1'b1;
        req_valid = 1'b1; req_burst = 1'b0; req_addr = ~a; #1;
        chk(dstb_n == 2'b11, "R4 stalled strobe", dstb_n, 2'b11);
        chk(ad_n == e, "R4 stalled data", ad_n, e);
        chk(drq_n == src, "R4 drq", drq_n, src);
      end
      @(negedge clk); lhold = 1'b0; tm_in_n = 2'b11; req_valid = 1'b0; #1;
      chk(dstb_n == 2'b00, "R3 strobe", dstb_n, 2'b00);
      chk(ad_n == e, "R3 data", ad_n, e);
      chk(drq_n == 1'b1, "R4 drq idle", drq_n, 1);
    end
    @(negedge clk); #1;
    chk(!ad_oe && dstb_n == 2'b11, "R5 release", {ad_oe, dstb_n}, 3'b011);
    wait_ack(d, s, noack, {64{1'b1}});
    finish_txn(noack ? 2'b11 : s);
  endtask

  task automatic do_single(input int d, input logic [1:0] s, input bit noack,
                           input logic [31:0] a, input logic [31:0] w);
    logic [63:0] e;
    e = {32'hFFFF_FFFF, ~w};
    @(negedge clk);
    req_valid = 1'b1; req_burst = 1'b0; req_addr = a; req_data = {96'h0, w}; #1;
    @(negedge clk); req_valid = 1'b0; #1;
    chk(!start_n && burst_n, "R2 single start", {start_n, burst_n}, 2'b01);
    @(negedge clk); ack_n = 1'b0; tm_in_n = ~s; lhold = 1'b1; #1;
    chk(ad_n == e && dstb_n == 2'b10, "R6 first data", ad_n, e);
    chk(!done, "R6 early ack", done, 0);
    lhold = 1'b0;
    wait_ack(d, s, noack, e);
    if (!noack) chk(ad_n == e, "R6 data at ack", ad_n, e);
    finish_txn(noack ? 2'b11 : s);
  endtask

  initial begin
    while (cyc < 150000) begin @(posedge clk); cyc++; end
    nfail++;
    $display("FAIL watchdog actual=%0d expected<150000", cyc);
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end

  initial begin
    int k;
    rst_n = 1'b0; req_valid = 1'b0; req_burst = 1'b0; req_addr = '0;
    req_data = '0; tmo_lim = 8'd4; lhold = 1'b0; ack_n = 1'b1; tm_in_n = 2'b11;
    repeat (3) @(negedge clk);
    #1;
    chk(!ad_oe && ad_n == '1 && dstb_n == 2'b11 && start_n && burst_n && drq_n
        && !done && !busy, "R1 reset", {ad_oe, dstb_n, start_n, done, busy}, 6'b011100);
    rst_n = 1'b1;
    @(negedge clk); #1;
    chk(!busy && !done && ad_n == '1, "R1 idle", {busy, done}, 0);
    k = 0;
    for (int h0 = 0; h0 < 3; h0++)
      for (int h1 = 0; h1 < 3; h1++)
        for (int src = 0; src < 2; src++)
          for (int d = 0; d < 3; d++)
            for (int s = 0; s < 4; s++) begin
              k++;
              do_burst(h0, h1, src[0], d, s[1:0], 1'b0, 32'h4000_0000 + k * 16,
                       {32'hD000_0000 + k, 32'hC000_0000 + k * 3,
                        32'hB000_0000 + k * 5, 32'hA000_0000 + k * 7});
            end
    for (int l = 0; l < 4; l++) begin
      tmo_lim = l[7:0];
      do_burst(1, 0, 1'b1, 0, 2'b00, 1'b1, 32'h0000_1230 + l, {4{32'h5A5A_0000 + l}});
      do_single(0, 2'b00, 1'b1, 32'h0000_2000 + l, 32'h1357_0000 + l);
    end
    tmo_lim = 8'd5;
    for (int d = 0; d < 4; d++)
      for (int s = 0; s < 4; s++)
        do_single(d, s[1:0], 1'b0, 32'h8000_0000 + d * 4 + s, 32'h2468_0000 + d * 16 + s);
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end
endmodule